// File: doc/BRIEF.md
# Page Half-Line Swap Engine

This block keeps the contents of a tiled memory page consistent when the page is moved to a physical frame whose selected address bit (normally bit 17) differs from the frame it was in before. It holds one remembered bit per page in a small on-chip map. A save command records the selected physical-address bit of a page's current frame. A later restore command carries the selected bit of the page's new frame. When the two bits differ, the engine walks the page over a single-port synchronous RAM. In every 128-byte group it exchanges the low 64 bytes with the high 64 bytes, and then it reports the page as dirty.

The caller presents the selected address bit, not the full physical address. The caller also gives the word address of the page base in the RAM. Commands are taken only while the engine is idle. The walk is a state machine with these states:
- `S_IDLE`: waits for a command.
- `S_CHECK`: compares the remembered bit with the new one.
- `S_RD_LO` and `S_LD_LO`: read the low half of a group into an eight-word buffer, one word at a time.
- `S_RD_HI` and `S_MV_LO`: read each high-half word and write it down into the low half.
- `S_WR_HI`: writes the buffered words into the high half.
- `S_FINISH`: completes the command.

The transitions are as follows:
- `S_IDLE` goes to `S_CHECK` on an accepted restore.
- `S_CHECK` goes to `S_RD_LO` when the bits differ and the map is present. Otherwise it goes to `S_FINISH`.
- `S_RD_LO` goes to `S_LD_LO`. `S_LD_LO` loops back to `S_RD_LO` until the eighth word, then goes to `S_RD_HI`.
- `S_RD_HI` goes to `S_MV_LO`. `S_MV_LO` loops back to `S_RD_HI` until the eighth word, then goes to `S_WR_HI`.
- `S_WR_HI` stays for eight words. It then goes back to `S_RD_LO` for the next group, or to `S_FINISH` after the last group.
- `S_FINISH` always returns to `S_IDLE`.

Top module: `page_swap_engine`

## Requirements
- R1: After reset, `busy`, `done`, `dirty` and `ram_en` are low. The page map is empty and marked absent, so a restore issued before any save performs no swap.
- R2: A save command (`cmd_op`=0) accepted while idle writes `cmd_pa_bit` into the entry of `cmd_page`, either setting it or clearing it. It marks the map present. It does not raise `busy` and makes no RAM access.
- R3: A restore command (`cmd_op`=1) issued while the map is absent makes no RAM access. `done` is high in the second cycle after the accepting edge, and `dirty` stays low.
- R4: A restore whose `cmd_pa_bit` equals the remembered bit of `cmd_page` behaves exactly as in R3.
- R5: A restore whose bit differs from the remembered bit swaps the page in place. RAM words are 8 bytes, and page word w sits at address `cmd_base`+w. Each word w (0 to 511) ends up holding the value that word w XOR 8 held before, so within each 16-word group words 0 to 7 trade places with words 8 to 15.
- R6: `dirty` is high, with `dirty_page` equal to the restored page, exactly in the `done` cycle of a restore that swapped, and never otherwise.
- R7: `busy` is high from the accepting edge through the `done` cycle. `done` lasts one cycle and is followed by idle. For a swap, `done` is high in cycle 1282 after the accepting edge.
- R8: A command presented while `busy` is high is ignored. A save issued during a walk leaves the map unchanged.
- R9: Every RAM access of a walk falls inside the window `cmd_base` to `cmd_base`+511. `ram_we` is only high together with `ram_en`. A swap takes exactly 1024 accesses.
- R10: A restore never changes the remembered bit. Repeating the same mismatching restore swaps the page again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = save, 1 = restore |
| cmd_page | input | 4 | Page index |
| cmd_pa_bit | input | 1 | Selected physical-address bit of the page's current frame |
| cmd_base | input | 16 | RAM word address of the page base (restore) |
| busy | output | 1 | Engine occupied with a restore |
| done | output | 1 | One-cycle completion of a restore |
| dirty | output | 1 | The completed restore swapped the page |
| dirty_page | output | 4 | Page index qualified by `dirty` |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write (read when low) |
| ram_addr | output | 16 | RAM word address |
| ram_wdata | output | 64 | RAM write data |
| ram_rdata | input | 64 | RAM read data, valid one cycle after a read |

## Verification
Command inputs are driven on the falling edge, so each command is taken at the next rising edge. Every output is sampled on the falling edges that follow, counted from that accepting edge.
- A restore that does not swap must show `done` at the second falling edge.
- A swap must show `done` at falling edge 1282, which comes from 40 cycles per group over 32 groups plus the check and finish cycles.
- `dirty` and `dirty_page` are sampled on that same falling edge.
- Idle is checked one falling edge later.

The RAM contents are compared against the XOR-8 word map only once `done` has been seen. The access count and the address window are gathered on every falling edge of the walk.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_CHECK  = 3'd1,
        S_RD_LO  = 3'd2,
        S_LD_LO  = 3'd3,
        S_RD_HI  = 3'd4,
        S_MV_LO  = 3'd5,
        S_WR_HI  = 3'd6,
        S_FINISH = 3'd7
    } walk_state_t;

    typedef enum logic {
        OP_SAVE    = 1'b0,
        OP_RESTORE = 1'b1
    } cmd_op_t;

endpackage

// File: rtl/psw_bitmap.sv
module psw_bitmap #(
    parameter int NUM_PAGES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         save_en,
    input  logic [$clog2(NUM_PAGES)-1:0] save_idx,
    input  logic                         save_bit,
    input  logic [$clog2(NUM_PAGES)-1:0] rd_idx,
    output logic                         rd_bit,
    output logic                         map_valid
);
    logic [NUM_PAGES-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q    <= '0;
            map_valid <= 1'b0;
        end else if (save_en) begin
            bits_q[save_idx] <= save_bit;
            map_valid        <= 1'b1;
        end
    end

    assign rd_bit = bits_q[rd_idx];

    // R2: a save lands in the addressed entry and marks the map present
    assert_save_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> (bits_q[$past(save_idx)] == $past(save_bit)) && map_valid);

    // R1: once present the map stays present until reset
    assert_map_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid |=> map_valid);
endmodule

// File: rtl/psw_half_buf.sv
module psw_half_buf #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] widx,
    input  logic [WORD_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] ridx,
    output logic [WORD_W-1:0]        rdata
);
    logic [WORD_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (widx == i[$clog2(DEPTH)-1:0])) begin
                slot[i] <= wdata;
            end
        end
    end

    assign rdata = slot[ridx];
endmodule

// File: rtl/psw_walk_fsm.sv
module psw_walk_fsm
    import psw_pkg::*;
#(
    parameter int RAM_AW     = 16,
    parameter int WORD_W     = 64,
    parameter int HALF_WORDS = 8,
    parameter int NUM_GROUPS = 32,
    parameter int PAGE_IDX_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [PAGE_IDX_W-1:0]      start_page,
    input  logic [RAM_AW-1:0]          start_base,
    input  logic                       start_bit,
    input  logic                       stored_bit,
    input  logic                       map_valid,
    output logic [PAGE_IDX_W-1:0]      page_q,
    output logic                       busy,
    output logic                       done,
    output logic                       dirty,
    output logic                       ram_en,
    output logic                       ram_we,
    output logic [RAM_AW-1:0]          ram_addr,
    output logic [WORD_W-1:0]          ram_wdata,
    input  logic [WORD_W-1:0]          ram_rdata,
    output logic                       buf_we,
    output logic [$clog2(HALF_WORDS)-1:0] buf_idx,
    input  logic [WORD_W-1:0]          buf_rdata
);
    localparam int HALF_W     = $clog2(HALF_WORDS);
    localparam int GRP_W      = $clog2(NUM_GROUPS);
    localparam int PAGE_WORDS = 2 * HALF_WORDS * NUM_GROUPS;

    walk_state_t           state, state_nx;
    logic [GRP_W-1:0]      grp;
    logic [HALF_W-1:0]     idx;
    logic [RAM_AW-1:0]     base_q;
    logic                  newbit_q;
    logic                  swapped_q;
    logic                  need_swap;
    logic                  idx_last;
    logic                  grp_last;
    logic                  hi_sel;
    logic [GRP_W+HALF_W:0] offset;

    assign need_swap = map_valid && (stored_bit != newbit_q);
    assign idx_last  = (idx == HALF_W'(HALF_WORDS - 1));
    assign grp_last  = (grp == GRP_W'(NUM_GROUPS - 1));

    // state register and walk counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            grp       <= '0;
            idx       <= '0;
            page_q    <= '0;
            base_q    <= '0;
            newbit_q  <= 1'b0;
            swapped_q <= 1'b0;
        end else begin
            state <= state_nx;
            case (state)
                S_IDLE: if (start) begin
                    page_q    <= start_page;
                    base_q    <= start_base;
                    newbit_q  <= start_bit;
                    grp       <= '0;
                    idx       <= '0;
                    swapped_q <= 1'b0;
                end
                S_CHECK: if (need_swap) swapped_q <= 1'b1;
                S_LD_LO, S_MV_LO: idx <= idx + 1'b1;
                S_WR_HI: begin
                    idx <= idx + 1'b1;
                    if (idx_last) grp <= grp + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   state_nx = start ? S_CHECK : S_IDLE;
            S_CHECK:  state_nx = need_swap ? S_RD_LO : S_FINISH;
            S_RD_LO:  state_nx = S_LD_LO;
            S_LD_LO:  state_nx = idx_last ? S_RD_HI : S_RD_LO;
            S_RD_HI:  state_nx = S_MV_LO;
            S_MV_LO:  state_nx = idx_last ? S_WR_HI : S_RD_HI;
            S_WR_HI:  state_nx = idx_last ? (grp_last ? S_FINISH : S_RD_LO) : S_WR_HI;
            S_FINISH: state_nx = S_IDLE;
        endcase
    end

    assign hi_sel = (state == S_RD_HI) || (state == S_WR_HI);
    assign offset = {grp, hi_sel, idx};

    // outputs
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_wdata = ram_rdata;
        buf_we    = 1'b0;
        done      = 1'b0;
        dirty     = 1'b0;
        unique case (state)
            S_RD_LO, S_RD_HI: ram_en = 1'b1;
            S_LD_LO:          buf_we = 1'b1;
            S_MV_LO: begin
                ram_en = 1'b1;
                ram_we = 1'b1;
            end
            S_WR_HI: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_wdata = buf_rdata;
            end
            S_FINISH: begin
                done  = 1'b1;
                dirty = swapped_q;
            end
            default: ;
        endcase
    end

    assign ram_addr = base_q + RAM_AW'(offset);
    assign buf_idx  = idx;
    assign busy     = (state != S_IDLE);

    assert_we_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_en);
    assert_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (RAM_AW'(ram_addr - base_q) < RAM_AW'(PAGE_WORDS)));
    assert_dirty_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dirty |-> done);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    assert_done_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_check_no_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !ram_en);
endmodule

// File: rtl/page_swap_engine.sv
module page_swap_engine
    import psw_pkg::*;
#(
    parameter int PAGE_BYTES  = 4096,
    parameter int WORD_BYTES  = 8,
    parameter int GROUP_BYTES = 128,
    parameter int NUM_PAGES   = 16,
    parameter int RAM_AW      = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic                         cmd_op,
    input  logic [$clog2(NUM_PAGES)-1:0] cmd_page,
    input  logic                         cmd_pa_bit,
    input  logic [RAM_AW-1:0]            cmd_base,
    output logic                         busy,
    output logic                         done,
    output logic                         dirty,
    output logic [$clog2(NUM_PAGES)-1:0] dirty_page,
    output logic                         ram_en,
    output logic                         ram_we,
    output logic [RAM_AW-1:0]            ram_addr,
    output logic [WORD_BYTES*8-1:0]      ram_wdata,
    input  logic [WORD_BYTES*8-1:0]      ram_rdata
);
    localparam int WORD_W      = WORD_BYTES * 8;
    localparam int GROUP_WORDS = GROUP_BYTES / WORD_BYTES;
    localparam int HALF_WORDS  = GROUP_WORDS / 2;
    localparam int NUM_GROUPS  = PAGE_BYTES / GROUP_BYTES;
    localparam int PAGE_IDX_W  = $clog2(NUM_PAGES);
    localparam int HALF_W      = $clog2(HALF_WORDS);

    logic                  accept, save_en, start;
    logic                  stored_bit, map_valid;
    logic [PAGE_IDX_W-1:0] page_q;
    logic                  buf_we;
    logic [HALF_W-1:0]     buf_idx;
    logic [WORD_W-1:0]     buf_rdata;

    assign accept  = cmd_valid && !busy;
    assign save_en = accept && (cmd_op == OP_SAVE);
    assign start   = accept && (cmd_op == OP_RESTORE);

    psw_bitmap #(.NUM_PAGES(NUM_PAGES)) u_map (
        .clk(clk), .rst_n(rst_n),
        .save_en(save_en), .save_idx(cmd_page), .save_bit(cmd_pa_bit),
        .rd_idx(page_q), .rd_bit(stored_bit), .map_valid(map_valid)
    );

    psw_half_buf #(.DEPTH(HALF_WORDS), .WORD_W(WORD_W)) u_buf (
        .clk(clk), .we(buf_we), .widx(buf_idx), .wdata(ram_rdata),
        .ridx(buf_idx), .rdata(buf_rdata)
    );

    psw_walk_fsm #(
        .RAM_AW(RAM_AW), .WORD_W(WORD_W), .HALF_WORDS(HALF_WORDS),
        .NUM_GROUPS(NUM_GROUPS), .PAGE_IDX_W(PAGE_IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_page(cmd_page), .start_base(cmd_base),
        .start_bit(cmd_pa_bit), .stored_bit(stored_bit), .map_valid(map_valid),
        .page_q(page_q), .busy(busy), .done(done), .dirty(dirty),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_rdata(buf_rdata)
    );

    assign dirty_page = page_q;

    // R8: no command can start while a restore is in flight
    assert_busy_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/page_swap_engine_tb.sv
`timescale 1ns/1ps
module page_swap_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_op, cmd_pa_bit;
    logic [3:0]  cmd_page;
    logic [15:0] cmd_base;
    logic        busy, done, dirty;
    logic [3:0]  dirty_page;
    logic        ram_en, ram_we;
    logic [15:0] ram_addr;
    logic [63:0] ram_wdata;
    logic [63:0] ram_rdata;

    always #2 clk = ~clk;

    page_swap_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_page(cmd_page), .cmd_pa_bit(cmd_pa_bit), .cmd_base(cmd_base),
        .busy(busy), .done(done), .dirty(dirty), .dirty_page(dirty_page),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    logic [63:0] mem [0:2047];
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr[10:0]] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr[10:0]];
        end
    end

    int total = 0, bad = 0;
    int ram_ops = 0, range_err = 0, win_lo = 0, win_hi = 0;
    bit swp [4];

    always @(negedge clk) begin
        if (rst_n && ram_en) begin
            ram_ops++;
            if (int'(ram_addr) < win_lo || int'(ram_addr) > win_hi) range_err++;
        end
        if (rst_n && ram_we && !ram_en) range_err++;
    end

    function automatic logic [63:0] pat(input int a);
        return {32'hC0DE_0000 | 32'(a), ~32'(a)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        for (int p = 0; p < 4; p++) begin
            int badw = -1;
            for (int w = 0; w < 512; w++) begin
                int src = p*512 + (swp[p] ? (w ^ 8) : w);
                if (badw < 0 && mem[p*512 + w] !== pat(src)) badw = w;
            end
            chk(badw < 0, req, $sformatf("page %0d contents word", p),
                badw, -1);
        end
    endtask

    task automatic do_save(input int page, input bit b);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 0; cmd_page = 4'(page); cmd_pa_bit = b;
        @(negedge clk);
        cmd_valid = 0;
        chk(!busy && !done && !ram_en, "R2", "save leaves engine idle",
            {busy, done, ram_en}, 0);
    endtask

    task automatic run_restore(input int page, input bit b, input bit exp_swap,
                               input bit inject, input string req);
        int k;
        bit busy_ok;
        bit dirty_s;
        int dpage;
        int base;
        base = page * 512;
        ram_ops = 0; range_err = 0; win_lo = base; win_hi = base + 511;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 1; cmd_page = 4'(page); cmd_pa_bit = b;
        cmd_base = 16'(base);
        @(negedge clk);
        cmd_valid = 0;
        k = 1;
        busy_ok = busy;
        while (!done && k < 4000) begin
            if (inject && k == 10) begin
                cmd_valid = 1; cmd_op = 0; cmd_page = 4'(page); cmd_pa_bit = b;
            end else begin
                cmd_valid = 0;
            end
            @(negedge clk);
            k++;
            if (!busy) busy_ok = 0;
        end
        cmd_valid = 0;
        dirty_s = dirty;
        dpage = int'(dirty_page);
        chk(k == (exp_swap ? 1282 : 2), req, "done cycle", k, exp_swap ? 1282 : 2);
        chk(busy_ok, "R7", "busy held until done", busy_ok, 1);
        chk(dirty_s == exp_swap, "R6", "dirty at done", dirty_s, exp_swap);
        if (exp_swap) chk(dpage == page, "R6", "dirty_page", dpage, page);
        chk(ram_ops == (exp_swap ? 1024 : 0), "R9", "RAM access count",
            ram_ops, exp_swap ? 1024 : 0);
        chk(range_err == 0, "R9", "accesses outside window", range_err, 0);
        @(negedge clk);
        chk(!busy && !done && !dirty, "R7", "idle after done",
            {busy, done, dirty}, 0);
        if (exp_swap) swp[page] = ~swp[page];
        check_mem(req);
    endtask

    task automatic t_reset();
        rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_page = 0; cmd_pa_bit = 0;
        cmd_base = 0;
        repeat (3) @(negedge clk);
        chk({busy, done, dirty, ram_en} == 0, "R1", "outputs in reset",
            {busy, done, dirty, ram_en}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk({busy, done, dirty, ram_en} == 0, "R1", "outputs after reset",
            {busy, done, dirty, ram_en}, 0);
    endtask

    task automatic t_absent_map();
        run_restore(2, 1'b1, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_match();
        do_save(2, 1'b1);
        run_restore(2, 1'b1, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_swap();
        run_restore(2, 1'b0, 1'b1, 1'b0, "R5");
    endtask

    task automatic t_restore_keeps_bit();
        run_restore(2, 1'b0, 1'b1, 1'b0, "R10");
    endtask

    task automatic t_save_clears();
        do_save(0, 1'b1);
        do_save(0, 1'b0);
        run_restore(0, 1'b0, 1'b0, 1'b0, "R2");
    endtask

    task automatic t_busy_ignore();
        do_save(3, 1'b0);
        run_restore(3, 1'b1, 1'b1, 1'b1, "R8");
        run_restore(3, 1'b1, 1'b1, 1'b0, "R8");
    endtask

    task automatic t_reset_clears_map();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        run_restore(2, 1'b0, 1'b0, 1'b0, "R1");
    endtask

    initial begin
        for (int a = 0; a < 2048; a++) mem[a] = pat(a);
        for (int p = 0; p < 4; p++) swp[p] = 0;
        t_reset();
        t_absent_map();
        t_match();
        t_swap();
        t_restore_keeps_bit();
        t_save_clears();
        t_busy_ignore();
        t_reset_clears_map();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule